// File: doc/BRIEF.md
# Vector Rotate-and-Mask Unit

This block is a 128-bit SIMD datapath. It splits its operands into lanes. It can use four 32-bit lanes or two 64-bit lanes. Each lane reads three fields from its own control element: a rotate count, a mask start position and a mask stop position. The lane rotates its source element left by the count. It then builds a contiguous run of ones from the start position to the stop position, counting with the most significant bit as position 0. When the start position lies after the stop position, the run wraps around the end of the lane.

The operation select picks one of two results for each lane:
- **Mask mode:** the rotated element with every bit outside the run cleared.
- **Insert mode:** the rotated bits where the run is set, and the old destination bits everywhere else.

An operation enters through a valid/ready handshake together with its lane-size and operation selects. It passes through one register stage. The result is held under a second valid/ready handshake until a consumer takes it.

Top module: `vec_rotmask_unit`

## Requirements
- R1: With `inDwMode`=0 the vector is four independent 32-bit lanes, and lane k occupies bits [32k+31:32k] of every vector.
- R2: With `inDwMode`=1 the vector is two independent 64-bit lanes, and lane k occupies bits [64k+63:64k].
- R3: The rotate count is the low 5 bits (32-bit lanes) or the low 6 bits (64-bit lanes) of the control element. The source element is rotated left by that count.
- R4: The mask start b comes from control bits [20:16] (32-bit lanes) or [21:16] (64-bit lanes). The mask stop e comes from bits [12:8] or [13:8]. Positions are numbered with the element's MSB as 0. When b <= e the mask is one exactly at positions b through e, so b == e gives a single set bit.
- R5: When b > e the mask is one at positions 0 through e and at positions b through the last position of the lane, and zero elsewhere.
- R6: With `inInsert`=0 each lane result is the rotated source ANDed with the mask.
- R7: With `inInsert`=1 each lane result takes rotated-source bits where the mask is 1 and `inDst` bits where the mask is 0.
- R8: Control bits outside the count, start and stop fields have no effect on the result.
- R9: After the synchronous active-low reset, `outValid` is 0 and `inReady` is 1.
- R10: While `outValid`=1 and `outReady`=0, `outData` and `outValid` hold their values and `inReady` is 0.
- R11: The lane-size and operation selects are captured with each operation. With `outReady` held high, operations of mixed modes are accepted on back-to-back cycles and come out in order, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An operation is offered |
| inReady | output | 1 | The unit accepts the offered operation this cycle |
| inSrc | input | 128 | Source vector to rotate |
| inCtl | input | 128 | Control vector: count, start and stop per lane |
| inDst | input | 128 | Old destination vector, merged in insert mode |
| inDwMode | input | 1 | 0: 32-bit lanes, 1: 64-bit lanes |
| inInsert | input | 1 | 0: mask mode, 1: insert mode |
| outValid | output | 1 | A result is available |
| outReady | input | 1 | The consumer takes the result this cycle |
| outData | output | 128 | Result vector |

## Verification
Two events can fall in the same cycle: the stage hands its current result to the consumer, and it accepts the next operation. The bench provokes this by toggling `outReady` at random on most cycles while offering operations. It also holds `outReady` high through a run of back-to-back operations whose modes alternate. In both cases every popped result is compared in order against a bench model computed bit by bit. During stalls the bench confirms that the held data does not move and that `inReady` stays low.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int VEC_W     = 128;
  localparam int WORD_W    = 32;
  localparam int DWORD_W   = 64;
  localparam int BEG_LSB   = 16;
  localparam int END_LSB   = 8;

  typedef struct packed {
    logic load;
  } vrm_strobe_t;
endpackage

// File: rtl/vrm_lane.sv
module vrm_lane #(
  parameter int LANE_W  = 32,
  parameter int IDX_W   = $clog2(LANE_W),
  parameter int BEG_LSB = 16,
  parameter int END_LSB = 8
) (
  input  logic              insertOp,
  input  logic [LANE_W-1:0] srcElt,
  input  logic [LANE_W-1:0] ctlElt,
  input  logic [LANE_W-1:0] dstElt,
  output logic [LANE_W-1:0] resElt,
  output logic [LANE_W-1:0] maskElt,
  output logic [IDX_W-1:0]  begIdx,
  output logic [IDX_W-1:0]  endIdx
);
  logic [IDX_W-1:0]    rotAmt;
  logic [2*LANE_W-1:0] dblShift;
  logic [LANE_W-1:0]   rotated;
  logic [LANE_W-1:0]   allOnes;
  logic [LANE_W-1:0]   baseMask;

  assign rotAmt = ctlElt[IDX_W-1:0];
  assign begIdx = ctlElt[BEG_LSB +: IDX_W];
  assign endIdx = ctlElt[END_LSB +: IDX_W];
  assign allOnes = '1;

  always_comb begin
    dblShift = {srcElt, srcElt} << rotAmt;
    rotated  = dblShift[2*LANE_W-1:LANE_W];
    baseMask = (allOnes >> begIdx) ^ ((allOnes >> endIdx) >> 1);
    maskElt  = (begIdx > endIdx) ? ~baseMask : baseMask;
    if (insertOp) resElt = (rotated & maskElt) | (dstElt & ~maskElt);
    else          resElt = rotated & maskElt;
  end
endmodule

// File: rtl/vrm_ctrl.sv
module vrm_ctrl
  import vrm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output vrm_strobe_t strb
);
  logic fullQ;

  assign inReady   = !fullQ || outReady;
  assign strb.load = inValid && inReady;
  assign outValid  = fullQ;

  always_ff @(posedge clk) begin
    if (!rstN)          fullQ <= 1'b0;
    else if (strb.load) fullQ <= 1'b1;
    else if (outReady)  fullQ <= 1'b0;
  end

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);
endmodule

// File: rtl/vrm_datapath.sv
module vrm_datapath
  import vrm_pkg::*;
#(
  parameter int DATA_W = VEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  vrm_strobe_t       strb,
  input  logic [DATA_W-1:0] inSrc,
  input  logic [DATA_W-1:0] inCtl,
  input  logic [DATA_W-1:0] inDst,
  input  logic              inDwMode,
  input  logic              inInsert,
  output logic [DATA_W-1:0] outData
);
  localparam int WORD_LANES = DATA_W / WORD_W;
  localparam int DW_LANES   = DATA_W / DWORD_W;
  localparam int WIDX_W     = $clog2(WORD_W);
  localparam int DIDX_W     = $clog2(DWORD_W);

  logic [DATA_W-1:0] wordRes, wordMask, dwRes, dwMask;
  logic [DATA_W-1:0] nextData, selMask, dataQ;

  genvar gi;
  generate
    for (gi = 0; gi < WORD_LANES; gi++) begin : g_word
      logic [WIDX_W-1:0] begW, endW;
      vrm_lane #(.LANE_W(WORD_W), .BEG_LSB(BEG_LSB), .END_LSB(END_LSB)) u_lane (
        .insertOp(inInsert),
        .srcElt  (inSrc[gi*WORD_W +: WORD_W]),
        .ctlElt  (inCtl[gi*WORD_W +: WORD_W]),
        .dstElt  (inDst[gi*WORD_W +: WORD_W]),
        .resElt  (wordRes[gi*WORD_W +: WORD_W]),
        .maskElt (wordMask[gi*WORD_W +: WORD_W]),
        .begIdx  (begW),
        .endIdx  (endW)
      );
      // R4
      word_run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        (begW <= endW) |-> ($countones(wordMask[gi*WORD_W +: WORD_W]) ==
                            32'(endW) - 32'(begW) + 32'd1));
      // R5
      word_wrap_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        (begW > endW) |-> ($countones(wordMask[gi*WORD_W +: WORD_W]) ==
                           32'(WORD_W) - (32'(begW) - 32'(endW) - 32'd1)));
    end
    for (gi = 0; gi < DW_LANES; gi++) begin : g_dw
      logic [DIDX_W-1:0] begD, endD;
      vrm_lane #(.LANE_W(DWORD_W), .BEG_LSB(BEG_LSB), .END_LSB(END_LSB)) u_lane (
        .insertOp(inInsert),
        .srcElt  (inSrc[gi*DWORD_W +: DWORD_W]),
        .ctlElt  (inCtl[gi*DWORD_W +: DWORD_W]),
        .dstElt  (inDst[gi*DWORD_W +: DWORD_W]),
        .resElt  (dwRes[gi*DWORD_W +: DWORD_W]),
        .maskElt (dwMask[gi*DWORD_W +: DWORD_W]),
        .begIdx  (begD),
        .endIdx  (endD)
      );
      // R4
      dw_run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        (begD <= endD) |-> ($countones(dwMask[gi*DWORD_W +: DWORD_W]) ==
                            32'(endD) - 32'(begD) + 32'd1));
      // R5
      dw_wrap_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        (begD > endD) |-> ($countones(dwMask[gi*DWORD_W +: DWORD_W]) ==
                           32'(DWORD_W) - (32'(begD) - 32'(endD) - 32'd1)));
    end
  endgenerate

  assign nextData = inDwMode ? dwRes  : wordRes;
  assign selMask  = inDwMode ? dwMask : wordMask;

  always_ff @(posedge clk) begin
    if (!rstN)          dataQ <= '0;
    else if (strb.load) dataQ <= nextData;
  end

  assign outData = dataQ;

  // R6
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !inInsert) |=> ((dataQ & ~$past(selMask)) == '0));
  // R7
  insert_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && inInsert) |=> ((dataQ & ~$past(selMask)) == ($past(inDst) & ~$past(selMask))));
endmodule

// File: rtl/vec_rotmask_unit.sv
module vec_rotmask_unit
  import vrm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [127:0] inSrc,
  input  logic [127:0] inCtl,
  input  logic [127:0] inDst,
  input  logic         inDwMode,
  input  logic         inInsert,
  output logic         outValid,
  input  logic         outReady,
  output logic [127:0] outData
);
  vrm_strobe_t strb;

  vrm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .strb    (strb)
  );

  vrm_datapath #(.DATA_W(VEC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inSrc   (inSrc),
    .inCtl   (inCtl),
    .inDst   (inDst),
    .inDwMode(inDwMode),
    .inInsert(inInsert),
    .outData (outData)
  );

  // R10
  stall_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));
  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: tb/vec_rotmask_unit_bench.sv
`timescale 1ns/1ps
module vec_rotmask_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inSrc = '0, inCtl = '0, inDst = '0;
  logic         inDwMode = 1'b0, inInsert = 1'b0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] outData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit readyForce = 0;
  bit stallPending = 0;
  logic [127:0] stallData;
  logic [127:0] expQ[$];
  string        tagQ[$];

  always #2.5 clk = ~clk;

  vec_rotmask_unit u_vec_rotmask_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refModel(input logic [127:0] s, input logic [127:0] c,
                                            input logic [127:0] d, input logic dw, input logic ins);
    logic [127:0] r = '0;
    int w = dw ? 64 : 32;
    for (int l = 0; l < 128 / w; l++) begin
      logic [63:0] sE, cE, dE;
      int n, b, e;
      sE = 64'(s >> (l * w));
      cE = 64'(c >> (l * w));
      dE = 64'(d >> (l * w));
      n = int'(cE) & (w - 1);
      b = int'(cE >> 16) & (w - 1);
      e = int'(cE >> 8) & (w - 1);
      for (int p = 0; p < w; p++) begin
        bit inM = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
        int sp = (p + n) % w;
        logic bitV = inM ? sE[w - 1 - sp] : (ins ? dE[w - 1 - p] : 1'b0);
        r[l * w + (w - 1 - p)] = bitV;
      end
    end
    return r;
  endfunction

  task automatic stepCycle(input logic v, input logic [127:0] s, input logic [127:0] c,
                           input logic [127:0] d, input logic dw, input logic ins,
                           input string tag, output bit acc);
    @(negedge clk);
    outReady = readyForce || ($urandom_range(0, 3) != 0);
    inValid = v; inSrc = s; inCtl = c; inDst = d; inDwMode = dw; inInsert = ins;
    #1;
    if (stallPending) chk(outData === stallData, "R10 held data", outData, stallData);
    stallPending = 0;
    if (outValid && !outReady) begin
      chk(inReady === 1'b0, "R10 inReady low while stalled", 128'(inReady), 128'd0);
      stallPending = 1;
      stallData = outData;
    end
    if (readyForce) chk(inReady === 1'b1, "R11 back-to-back accept", 128'(inReady), 128'd1);
    if (outValid && outReady) begin
      if (expQ.size() == 0) chk(1'b0, "R11 unexpected result", outData, '0);
      else begin
        logic [127:0] ex = expQ.pop_front();
        string t = tagQ.pop_front();
        chk(outData === ex, t, outData, ex);
      end
    end
    acc = v && inReady;
    if (acc) begin
      expQ.push_back(refModel(s, c, d, dw, ins));
      tagQ.push_back(tag);
    end
  endtask

  task automatic sendOp(input logic [127:0] s, input logic [127:0] c, input logic [127:0] d,
                        input logic dw, input logic ins, input string tag);
    bit acc = 0;
    while (!acc) stepCycle(1'b1, s, c, d, dw, ins, tag, acc);
  endtask

  task automatic drain();
    bit acc;
    while (expQ.size() != 0 || outValid) stepCycle(1'b0, '0, '0, '0, 1'b0, 1'b0, "idle", acc);
  endtask

  function automatic logic [31:0] wCtl(input int b, input int e, input int n);
    return (32'(b) << 16) | (32'(e) << 8) | 32'(n);
  endfunction

  function automatic logic [63:0] dCtl(input int b, input int e, input int n);
    return (64'(b) << 16) | (64'(e) << 8) | 64'(n);
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk(outValid === 1'b0, "R9 outValid after reset", 128'(outValid), 128'd0);
    chk(inReady === 1'b1, "R9 inReady after reset", 128'(inReady), 128'd1);

    // R4 single-bit mask, R1 word lanes
    sendOp('1, {4{wCtl(7, 7, 0)}}, '0, 1'b0, 1'b0, "R4 b==e single bit");
    sendOp({32'h1, 32'h2, 32'h3, 32'h4}, {wCtl(0, 31, 1), wCtl(0, 31, 2), wCtl(0, 31, 3), wCtl(0, 31, 4)},
           '0, 1'b0, 1'b0, "R1 independent word lanes");
    // R5 wrap-around mask
    sendOp('1, {4{wCtl(28, 3, 0)}}, '0, 1'b0, 1'b0, "R5 wrap word");
    sendOp({2{64'h0123_4567_89AB_CDEF}}, {2{dCtl(60, 2, 5)}}, '0, 1'b1, 1'b0, "R5 wrap dword");
    // R3 maximum rotate counts
    sendOp({4{32'h8000_0001}}, {4{wCtl(0, 31, 31)}}, '0, 1'b0, 1'b0, "R3 rotate 31");
    sendOp({2{64'h8000_0000_0000_0003}}, {2{dCtl(0, 63, 63)}}, '0, 1'b1, 1'b0, "R3 rotate 63");
    // R2 dword lanes, R7 insert
    sendOp({64'hAAAA_0000_FFFF_1234, 64'h5555_AAAA_0F0F_F0F0}, {dCtl(8, 40, 12), dCtl(50, 10, 33)},
           {2{64'hDEAD_BEEF_CAFE_F00D}}, 1'b1, 1'b1, "R2/R7 dword insert");
    sendOp({4{32'h1234_5678}}, {4{wCtl(4, 19, 9)}}, {4{32'hFFFF_FFFF}}, 1'b0, 1'b1, "R7 word insert");
    // R8 unused control bits set
    sendOp({4{32'hC3C3_5A5A}}, {4{wCtl(3, 20, 6) | 32'hFFE0_E0E0}}, {4{32'h0F0F_0F0F}},
           1'b0, 1'b1, "R8 high control bits ignored (word)");
    sendOp({2{64'hC3C3_5A5A_1111_2222}}, {2{dCtl(3, 50, 17) | 64'hFFFF_FFFF_FFC0_C0C0}}, '0,
           1'b1, 1'b0, "R8 high control bits ignored (dword)");
    drain();

    // R11 back-to-back mixed modes with outReady held high
    readyForce = 1;
    for (int k = 0; k < 8; k++) begin
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] c = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      sendOp(s, c, d, 1'(k & 1), 1'((k >> 1) & 1), "R11 mixed back-to-back");
    end
    drain();
    readyForce = 0;

    // Random phase: R6/R7 across R1/R2 with random backpressure
    for (int k = 0; k < 400; k++) begin
      bit acc;
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] c = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      logic dw = 1'($urandom_range(0, 1));
      logic ins = 1'($urandom_range(0, 1));
      string t = dw ? (ins ? "R2/R7 random" : "R2/R6 random") : (ins ? "R1/R7 random" : "R1/R6 random");
      if ($urandom_range(0, 3) == 0) stepCycle(1'b0, '0, '0, '0, 1'b0, 1'b0, "idle", acc);
      else sendOp(s, c, d, dw, ins, t);
    end
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule